// File: doc/BRIEF.md
# Multi-Timer GPIO Input Debouncer

This block cleans up a set of 32 general-purpose input pins (four groups of eight) before the rest of the chip sees them. Every raw pin first passes through a two-stage synchroniser. After that, each pin either passes straight through or goes through a stability filter. The filter lets the output take a new level only once the input has held that level, without interruption, for a programmed number of clock cycles.

There are three programmable periods, and they are shared by the whole set. Each pin chooses bypass or one of the three periods through a 2-bit selector. The two bits of that selector live in two separate configuration words: the word at offset 0x0 supplies the high bit and the word at offset 0x4 supplies the low bit. Software writes the selectors and the three periods through a simple synchronous register port. The block drives out the 32 filtered levels.

If a pin's filter settings are rewritten while it is counting, that pin's count starts again from zero. Its output keeps the value it already had until a full new period has passed.

Top module: `gpio_debounce_set`

## Requirements
- R1: The selector of pin i is {bit i of the word at offset 0x0, bit i of the word at offset 0x4}, so the 0x0 word gives the MSB and the 0x4 word gives the LSB. Selector 0 means bypass, and selectors 1, 2 and 3 choose period registers 1, 2 and 3.
- R2: A bypassed pin's output follows its raw input three clock edges after the input changes (two synchroniser stages plus the output register).
- R3: Take a pin whose selected period P is greater than zero, and let the raw input change to a steady new level before edge 1. The output takes that level at edge P+2 and not earlier.
- R4: If the synchronised input returns to the output level even once, the count starts again. The output then changes only after P further consecutive differing edges.
- R5: A period register holding 0 makes every pin that selects it behave as bypass.
- R6: The three period registers are independent. All pins with the same selector share one period.
- R7: A write to either configuration word clears the stability count of every pin. A write to period register k clears the count of every pin currently selecting k. A cleared pin keeps its output until a full new period has elapsed.
- R8: The configuration words sit at offsets 0x0 and 0x4 and hold 32 bits each. Period registers 1, 2 and 3 sit at offsets 0x8, 0xC and 0x10 and hold 24 bits each. Reads return the stored values, with bits 31:24 of a period reading as zero. Reads of any other offset return zero.
- R9: Writes to any offset other than the five mapped ones change no register.
- R10: Reset clears all five registers and all outputs. Every pin is therefore in bypass after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 32 | Raw pin levels, asynchronous to clk |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |
| pin_o | output | 32 | Filtered pin levels |

## Verification
The hardest situation to create from the ports is a write that restarts a count partway through, while the input keeps a differing level. From outside, the only sign of the restart is that the output changes later than it would have without the write.

The bench reaches this in three steps. It programs a period, raises the input, and then writes either the same period or the same selector word on a chosen edge while the count is running. It then checks that the output is still unchanged at the edge where an uninterrupted count would have finished, and that the output does change exactly P edges after the write.

A similar timed glitch injected in the middle of a count checks the restart on a bounce. A sweep that gives the pins all four selectors at once checks, in one pass, the reversed bit order and the three independent periods.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

  typedef logic [1:0] sel_t;

  localparam int NTMR = 3;

  // Build a pin selector from its two configuration bits.
  function automatic sel_t form_sel(input logic hi_bit, input logic lo_bit);
    return {hi_bit, lo_bit};
  endfunction

  // True when one more differing cycle completes the qualification period.
  function automatic logic qual_done(input logic [31:0] cnt, input logic [31:0] per);
    return (cnt + 32'd1) >= per;
  endfunction

  // Byte offset of a period register, counted from zero.
  function automatic int tmr_ofs(input int k);
    return 8 + 4 * k;
  endfunction

endpackage

// File: rtl/dbn_sync.sv
module dbn_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dbn_regs.sv
module dbn_regs
  import dbn_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int TW   = 24,
  parameter int AW   = 5,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [NPIN-1:0] cfg_hi,
  output logic [NPIN-1:0] cfg_lo,
  output logic [TW-1:0]   per_q [NTMR],
  output logic            wr_cfg,
  output logic [NTMR-1:0] wr_tmr
);
  localparam logic [AW-1:0] OFS_HI = AW'(0);
  localparam logic [AW-1:0] OFS_LO = AW'(4);

  logic hit_hi, hit_lo;
  assign hit_hi = bus_we && (bus_addr == OFS_HI);
  assign hit_lo = bus_we && (bus_addr == OFS_LO);
  assign wr_cfg = hit_hi || hit_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_hi <= '0;
      cfg_lo <= '0;
    end else begin
      if (hit_hi) cfg_hi <= bus_wdata[NPIN-1:0];
      if (hit_lo) cfg_lo <= bus_wdata[NPIN-1:0];
    end
  end

  for (genvar k = 0; k < NTMR; k++) begin : g_tmr
    localparam logic [AW-1:0] OFS_T = AW'(tmr_ofs(k));
    assign wr_tmr[k] = bus_we && (bus_addr == OFS_T);
    always_ff @(posedge clk) begin
      if (!rst_n)         per_q[k] <= '0;
      else if (wr_tmr[k]) per_q[k] <= bus_wdata[TW-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_HI) bus_rdata[NPIN-1:0] = cfg_hi;
    if (bus_addr == OFS_LO) bus_rdata[NPIN-1:0] = cfg_lo;
    for (int k = 0; k < NTMR; k++) begin
      if (bus_addr == AW'(tmr_ofs(k))) bus_rdata[TW-1:0] = per_q[k];
    end
  end
endmodule

// File: rtl/dbn_cell.sv
module dbn_cell
  import dbn_pkg::*;
#(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [TW-1:0] per,
  input  logic          restart,
  output logic          dout,
  output logic          byp,
  output logic          flip
);
  logic [TW-1:0] cnt_q;
  logic          diff;

  assign byp  = (per == '0);
  assign diff = din ^ dout;
  assign flip = !byp && !restart && diff && qual_done(32'(cnt_q), 32'(per));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout  <= 1'b0;
      cnt_q <= '0;
    end else if (byp) begin
      dout  <= din;
      cnt_q <= '0;
    end else if (restart || !diff) begin
      cnt_q <= '0;
    end else if (flip) begin
      dout  <= din;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + TW'(1);
    end
  end
endmodule

// File: rtl/gpio_debounce_set.sv
module gpio_debounce_set
  import dbn_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int TW   = 24,
  parameter int AW   = 5,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [NPIN-1:0] pin_o
);
  logic [NPIN-1:0] sync_q;
  logic [NPIN-1:0] cfg_hi, cfg_lo;
  logic [TW-1:0]   per_q [NTMR];
  logic            wr_cfg;
  logic [NTMR-1:0] wr_tmr;
  logic [NPIN-1:0] byp_v, flip_v, rst_v;

  dbn_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(sync_q)
  );

  dbn_regs #(.NPIN(NPIN), .TW(TW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_hi(cfg_hi),
    .cfg_lo(cfg_lo), .per_q(per_q), .wr_cfg(wr_cfg), .wr_tmr(wr_tmr)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    sel_t          sel;
    logic [TW-1:0] per_sel;
    logic          tmr_wr;

    assign sel = form_sel(cfg_hi[i], cfg_lo[i]);

    always_comb begin
      per_sel = '0;
      tmr_wr  = 1'b0;
      case (sel)
        2'd1: begin per_sel = per_q[0]; tmr_wr = wr_tmr[0]; end
        2'd2: begin per_sel = per_q[1]; tmr_wr = wr_tmr[1]; end
        2'd3: begin per_sel = per_q[2]; tmr_wr = wr_tmr[2]; end
        default: ;
      endcase
    end

    assign rst_v[i] = wr_cfg || tmr_wr;

    dbn_cell #(.TW(TW)) u_cell (
      .clk(clk), .rst_n(rst_n), .din(sync_q[i]), .per(per_sel),
      .restart(rst_v[i]), .dout(pin_o[i]), .byp(byp_v[i]), .flip(flip_v[i])
    );
  end
endmodule

// File: rtl/dbn_chk.sv
module dbn_chk
  import dbn_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int TW   = 24,
  parameter int AW   = 5,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [NPIN-1:0] pin_o,
  input logic [NPIN-1:0] sync_q,
  input logic [NPIN-1:0] cfg_hi,
  input logic [NPIN-1:0] cfg_lo,
  input logic [TW-1:0]   per_q [NTMR],
  input logic [NPIN-1:0] byp_v,
  input logic [NPIN-1:0] flip_v,
  input logic [NPIN-1:0] rst_v
);
  logic mapped;
  assign mapped = (bus_addr == AW'(0)) || (bus_addr == AW'(4)) ||
                  (bus_addr == AW'(8)) || (bus_addr == AW'(12)) ||
                  (bus_addr == AW'(16));

  AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_o ^ $past(sync_q)) & $past(byp_v)) == '0); // R2

  AST_NO_EARLY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_o ^ $past(pin_o)) & ~$past(byp_v) & ~$past(flip_v)) == '0); // R3

  AST_FLIP_TAKES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_o ^ $past(sync_q)) & $past(flip_v)) == '0); // R4

  AST_RESTART_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_o ^ $past(pin_o)) & $past(rst_v & ~byp_v)) == '0); // R7

  AST_CFG_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(0)) |=> cfg_hi == $past(bus_wdata[NPIN-1:0])); // R1

  AST_TMR1_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(8)) |=> per_q[0] == $past(bus_wdata[TW-1:0])); // R8

  AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !mapped) |=> ($stable(cfg_hi) && $stable(cfg_lo) &&
      $stable(per_q[0]) && $stable(per_q[1]) && $stable(per_q[2]))); // R9
endmodule

bind gpio_debounce_set dbn_chk #(.NPIN(NPIN), .TW(TW), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/gpio_debounce_set_test.sv
module gpio_debounce_set_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_i = '0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int per_m [4];

  gpio_debounce_set uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_o(pin_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Sweep layout: pin i uses selector i%4, so the 0x0 word holds 1 where (i>>1)&1
  // and the 0x4 word holds 1 where i&1.
  localparam logic [31:0] HI_PAT = 32'hCCCC_CCCC;
  localparam logic [31:0] LO_PAT = 32'hAAAA_AAAA;
  localparam logic [31:0] M_SEL1 = 32'h2222_2222;
  localparam logic [31:0] M_SEL2 = 32'h4444_4444;
  localparam logic [31:0] M_SEL3 = 32'h8888_8888;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected sweep output k edges after all inputs moved to level v.
  function automatic logic [31:0] sweep_exp(input int k, input logic v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      int lat;
      lat = (i % 4 == 0 || per_m[i % 4] == 0) ? 3 : 2 + per_m[i % 4];
      r[i] = (k >= lat) ? v : ~v;
    end
    return r;
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R10 reset state
    check("R10 outputs after reset", pin_o, 32'h0);
    rd_chk("R10 cfg hi reset", 5'h00, 32'h0);
    rd_chk("R10 cfg lo reset", 5'h04, 32'h0);
    rd_chk("R10 tmr1 reset", 5'h08, 32'h0);
    rd_chk("R10 tmr2 reset", 5'h0C, 32'h0);
    rd_chk("R10 tmr3 reset", 5'h10, 32'h0);

    // R2 bypass latency over several patterns
    foreach (per_m[j]) per_m[j] = 0;
    for (int p = 0; p < 4; p++) begin
      logic [31:0] v, old;
      v = 32'hA5C3_0F96 ^ (32'h1111_1111 * p) ^ {p[7:0], 24'h0};
      old = pin_o;
      @(negedge clk); pin_i = v;
      @(negedge clk); @(negedge clk);
      check("R2 bypass not before 3 edges", pin_o, old);
      @(negedge clk);
      check("R2 bypass after 3 edges", pin_o, v);
    end
    pin_i = '0; idle(5);

    // R8 readback and width
    wr(5'h00, 32'hDEAD_BEEF); rd_chk("R8 cfg hi readback", 5'h00, 32'hDEAD_BEEF);
    wr(5'h04, 32'h1234_5678); rd_chk("R8 cfg lo readback", 5'h04, 32'h1234_5678);
    wr(5'h08, 32'hFFFF_FFFF); rd_chk("R8 tmr1 24-bit", 5'h08, 32'h00FF_FFFF);
    wr(5'h0C, 32'h0ABC_DEF1); rd_chk("R8 tmr2 24-bit", 5'h0C, 32'h00BC_DEF1);
    wr(5'h10, 32'h0000_0042); rd_chk("R8 tmr3 readback", 5'h10, 32'h0000_0042);
    rd_chk("R8 unmapped read 0x14", 5'h14, 32'h0);
    rd_chk("R8 unmapped read 0x02", 5'h02, 32'h0);
    // R9 writes to unmapped offsets
    for (int a = 0; a < 32; a++) begin
      if (a != 0 && a != 4 && a != 8 && a != 12 && a != 16) wr(5'(a), 32'h5555_AAAA);
    end
    rd_chk("R9 cfg hi unchanged", 5'h00, 32'hDEAD_BEEF);
    rd_chk("R9 cfg lo unchanged", 5'h04, 32'h1234_5678);
    rd_chk("R9 tmr1 unchanged", 5'h08, 32'h00FF_FFFF);
    rd_chk("R9 tmr2 unchanged", 5'h0C, 32'h00BC_DEF1);
    rd_chk("R9 tmr3 unchanged", 5'h10, 32'h0000_0042);

    // R1 R3 R6 sweep: all four selectors at once, distinct periods
    wr(5'h00, 32'h0); wr(5'h04, 32'h0);
    per_m[1] = 3; per_m[2] = 5; per_m[3] = 8;
    wr(5'h08, 32'd3); wr(5'h0C, 32'd5); wr(5'h10, 32'd8);
    wr(5'h00, HI_PAT); wr(5'h04, LO_PAT);
    idle(15);
    check("R3 sweep start level", pin_o, 32'h0);
    for (int lvl = 1; lvl >= 0; lvl--) begin
      @(negedge clk); pin_i = lvl[0] ? 32'hFFFF_FFFF : 32'h0;
      for (int k = 1; k <= 12; k++) begin
        @(negedge clk);
        check($sformatf("R1 R3 R6 sweep lvl=%0d k=%0d", lvl, k), pin_o, sweep_exp(k, lvl[0]));
      end
      idle(4);
    end

    // R4 bounce restarts the count on selector 3 pins (P=8)
    @(negedge clk); pin_i = 32'hFFFF_FFFF;
    for (int k = 1; k <= 18; k++) begin
      @(negedge clk);
      if (k == 10) check("R4 no flip at unbroken time", pin_o & M_SEL3, 32'h0);
      if (k == 15) check("R4 still held before restarted count", pin_o & M_SEL3, 32'h0);
      if (k == 16) check("R4 flip after restarted count", pin_o & M_SEL3, M_SEL3);
      if (k == 5) pin_i = 32'h0;
      if (k == 6) pin_i = 32'hFFFF_FFFF;
    end
    pin_i = 32'h0; idle(20);
    check("R4 settled low", pin_o, 32'h0);

    // R5 period zero acts as bypass
    wr(5'h0C, 32'h0);
    idle(3);
    @(negedge clk); pin_i = 32'hFFFF_FFFF;
    @(negedge clk); @(negedge clk);
    check("R5 zero period not before 3 edges", pin_o & M_SEL2, 32'h0);
    @(negedge clk);
    check("R5 zero period follows at 3 edges", pin_o & M_SEL2, M_SEL2);
    check("R6 timer1 pins unaffected", pin_o & M_SEL1, 32'h0);
    rd_chk("R6 tmr1 kept", 5'h08, 32'd3);
    rd_chk("R6 tmr3 kept", 5'h10, 32'd8);
    pin_i = 32'h0; idle(20);

    // R7 restart by period write and by selector write (P=6 on selector 1)
    wr(5'h08, 32'd6);
    idle(20);
    for (int v = 0; v < 2; v++) begin
      @(negedge clk); pin_i = 32'hFFFF_FFFF;
      for (int k = 1; k <= 14; k++) begin
        @(negedge clk);
        if (k == 8)  check($sformatf("R7 held at unbroken time v=%0d", v), pin_o & M_SEL1, 32'h0);
        if (k == 10) check($sformatf("R7 held before new period v=%0d", v), pin_o & M_SEL1, 32'h0);
        if (k == 11) check($sformatf("R7 flip after new period v=%0d", v), pin_o & M_SEL1, M_SEL1);
        if (k == 4) begin
          bus_we = 1'b1;
          bus_addr = (v == 0) ? 5'h08 : 5'h04;
          bus_wdata = (v == 0) ? 32'd6 : LO_PAT;
        end
        if (k == 5) bus_we = 1'b0;
      end
      pin_i = 32'h0; idle(20);
    end
    check("R7 settled low", pin_o, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule